// File: doc/BRIEF.md
# Precise Interruption Commit Controller

This block sits at the retirement stage of an in-order core that completes a group of up to `NSLOT` instructions in each cycle. Every slot reports whether it holds an instruction, whether that instruction raised a fault or a trap (each with its own cause code), and whether it is a branch that was taken. The controller looks at the slots in program order, left to right. It finds the oldest slot that needs an interruption. From that it decides which instructions in the group may update architectural state.

A fault stops its own instruction and every younger one. A trap lets its own instruction finish and stops only the younger ones. When the taken-branch enable input is set, a taken branch counts as a trap with a fixed cause. The block reports the chosen event as registered outputs: the kind, the cause, and the restart address at which the event is reported. It also gives the entry address of the handler, which is either the operating-system vector table or a fixed firmware entry.

Delivering an event redirects fetch. The group presented in the cycle the event is visible is on the wrong path and is discarded.

Top module: `precise_commit_ctrl`

## Requirements
- R1: The event is taken from the lowest-numbered slot whose valid bit is 1 and that has a fault, a trap, or a qualifying taken branch. Slots whose valid bit is 0 are ignored completely, whatever flags they carry.
- R2: When the chosen event is a fault in slot k, `commit` bit i is 1 exactly for valid slots with i < k.
- R3: When the chosen event is a trap in slot k, `commit` bit i is 1 exactly for valid slots with i <= k.
- R4: A fault in slot k is reported with `ev_ip` = `grp_ip` + k*`STRIDE`, and `ev_trap` = 0.
- R5: A trap in slot k is reported at the address of the next instruction:
  - the slot's branch target when its taken flag is 1;
  - otherwise `grp_ip` + (k+1)*`STRIDE`, including for the last slot.
- R6: When `tb_en` = 1, a valid slot with its taken flag set and no explicit trap raises a trap with cause `TB_CAUSE`. When `tb_en` = 0, a taken flag never raises an event.
- R7: When a slot has both a fault and a trap or taken-branch condition, the fault wins. Its fault cause is reported, and nothing of the trap is visible.
- R8: The handler address depends on the event:
  - A fault whose cause bit is set in `FW_FAULT_MASK` goes to the firmware: `ev_fw` = 1 and `ev_handler` = `FW_ENTRY`.
  - Any other event gives `ev_fw` = 0 and `ev_handler` = `vt_base` + (`ev_trap`*2^`CW` + `ev_cause`)*`ENTRY_BYTES`.
- R9: The outputs appear one clock after the group is presented. A group with no event commits exactly its valid slots and leaves `ev_valid` = 0. An all-invalid group commits nothing.
- R10: The group presented in a cycle where `ev_valid` = 1 is flushed. The next cycle shows `commit` = 0 and `ev_valid` = 0.
- R11: While `rst_n` = 0, and on the first cycle after it rises, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_en | input | 1 | Taken-branch trap enable from the status register |
| grp_ip | input | AW | Address of slot 0 of the group |
| slot_vld | input | NSLOT | Slot holds an instruction |
| slot_flt | input | NSLOT | Slot raised a fault |
| slot_fcause | input | NSLOT*CW | Fault cause per slot (slot i at bits i*CW +: CW) |
| slot_trp | input | NSLOT | Slot raised a trap |
| slot_tcause | input | NSLOT*CW | Trap cause per slot |
| slot_brt | input | NSLOT | Slot is a taken branch |
| slot_btgt | input | NSLOT*AW | Branch target per slot |
| vt_base | input | AW | Vector table base address |
| commit | output | NSLOT | Per-slot commit enable |
| ev_valid | output | 1 | Interruption delivered / fetch redirect |
| ev_trap | output | 1 | 1 = trap, 0 = fault |
| ev_cause | output | CW | Cause code of the event |
| ev_ip | output | AW | Address at which the event is reported |
| ev_fw | output | 1 | Event goes to the firmware entry |
| ev_handler | output | AW | Handler entry address |

## Verification
Two pairs of functions can fall in the same cycle and are worth stressing:
- A fault and a trap, or a taken-branch trap, flagged on the same slot. The bench builds such slots on purpose.
- A flush of the wrong-path group and a fresh event in that group. The bench presents a faulting group in the cycle right after a delivered event.

In both cases a behavioural model in the bench predicts the per-slot commit mask, the event fields and the handler address. These are compared on every clock. Long random runs with high fault and trap rates then mix these collisions with invalid slots and tail-slot traps.

// File: rtl/precise_commit_ctrl.sv
module precise_commit_ctrl #(
  parameter int NSLOT = 3,
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int STRIDE = 16,
  parameter int ENTRY_BYTES = 256,
  parameter logic [CW-1:0] TB_CAUSE = 4'd9,
  parameter logic [(1<<CW)-1:0] FW_FAULT_MASK = 16'hC000,
  parameter logic [AW-1:0] FW_ENTRY = 32'hFFF0_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tb_en,
  input  logic [AW-1:0]       grp_ip,
  input  logic [NSLOT-1:0]    slot_vld,
  input  logic [NSLOT-1:0]    slot_flt,
  input  logic [NSLOT*CW-1:0] slot_fcause,
  input  logic [NSLOT-1:0]    slot_trp,
  input  logic [NSLOT*CW-1:0] slot_tcause,
  input  logic [NSLOT-1:0]    slot_brt,
  input  logic [NSLOT*AW-1:0] slot_btgt,
  input  logic [AW-1:0]       vt_base,
  output logic [NSLOT-1:0]    commit,
  output logic                ev_valid,
  output logic                ev_trap,
  output logic [CW-1:0]       ev_cause,
  output logic [AW-1:0]       ev_ip,
  output logic                ev_fw,
  output logic [AW-1:0]       ev_handler
);

  logic [NSLOT-1:0] c_mask;
  logic             c_hit, c_trap, c_fw;
  logic [CW-1:0]    c_cause;
  logic [AW-1:0]    c_ip, c_hdl;

  always_comb begin
    c_mask  = '0;
    c_hit   = 1'b0;
    c_trap  = 1'b0;
    c_cause = '0;
    c_ip    = '0;
    if (!ev_valid) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (!c_hit && slot_vld[i]) begin
          if (slot_flt[i]) begin
            c_hit   = 1'b1;
            c_cause = slot_fcause[i*CW +: CW];
            c_ip    = grp_ip + AW'(i) * AW'(STRIDE);
          end else begin
            c_mask[i] = 1'b1;
            if (slot_trp[i] || (tb_en && slot_brt[i])) begin
              c_hit   = 1'b1;
              c_trap  = 1'b1;
              c_cause = slot_trp[i] ? slot_tcause[i*CW +: CW] : TB_CAUSE;
              c_ip    = slot_brt[i] ? slot_btgt[i*AW +: AW]
                                    : grp_ip + AW'(i + 1) * AW'(STRIDE);
            end
          end
        end
      end
    end
  end

  assign c_fw  = c_hit && !c_trap && FW_FAULT_MASK[c_cause];
  assign c_hdl = c_fw ? FW_ENTRY
                      : vt_base + AW'({c_trap, c_cause}) * AW'(ENTRY_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      commit     <= '0;
      ev_valid   <= 1'b0;
      ev_trap    <= 1'b0;
      ev_cause   <= '0;
      ev_ip      <= '0;
      ev_fw      <= 1'b0;
      ev_handler <= '0;
    end else begin
      commit     <= c_mask;
      ev_valid   <= c_hit;
      ev_trap    <= c_hit && c_trap;
      ev_cause   <= c_hit ? c_cause : '0;
      ev_ip      <= c_hit ? c_ip : '0;
      ev_fw      <= c_fw;
      ev_handler <= c_hit ? c_hdl : '0;
    end
  end

  a_r10_flush_next: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |=> (commit == '0 && !ev_valid));

  a_r9_commit_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((commit & ~$past(slot_vld)) == '0));

  a_r9_quiet_commits_all: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ev_valid && !$past(ev_valid)) |-> commit == $past(slot_vld));

  a_r3_trap_self_commits: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_trap) |-> commit != '0);

  a_r8_fw_only_faults: assert property (@(posedge clk) disable iff (!rst_n)
    ev_fw |-> (ev_valid && !ev_trap && ev_handler == FW_ENTRY));

  a_r11_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |-> (!ev_trap && !ev_fw && ev_ip == '0));

endmodule

// File: tb/tb_precise_commit_ctrl.sv
`timescale 1ns/1ps
module tb_precise_commit_ctrl;
  localparam int N = 3, AW = 32, CW = 4, STRIDE = 16, EB = 256;
  localparam int TBC = 9;
  localparam logic [15:0] FWM = 16'hC000;
  localparam logic [AW-1:0] FWE = 32'hFFF0_0000;

  logic clk = 0, rst_n = 0, tb_en = 0;
  logic [AW-1:0] grp_ip = 0, vt_base = 0;
  logic [N-1:0] slot_vld = 0, slot_flt = 0, slot_trp = 0, slot_brt = 0;
  logic [N*CW-1:0] slot_fcause = 0, slot_tcause = 0;
  logic [N*AW-1:0] slot_btgt = 0;
  logic [N-1:0] commit;
  logic ev_valid, ev_trap, ev_fw;
  logic [CW-1:0] ev_cause;
  logic [AW-1:0] ev_ip, ev_handler;

  always #4 clk = ~clk;

  precise_commit_ctrl dut (.*);

  int vectors = 0, errs = 0;
  bit done = 0;
  string tag = "R11";

  logic [N-1:0] e_commit = 0, p_commit;
  logic e_ev = 0, e_trap = 0, e_fw = 0, p_ev, p_trap, p_fw;
  logic [CW-1:0] e_cause = 0, p_cause;
  logic [AW-1:0] e_ip = 0, e_hdl = 0, p_ip, p_hdl;

  task automatic predict();
    int k;
    p_commit = 0; p_ev = 0; p_trap = 0; p_fw = 0; p_cause = 0; p_ip = 0; p_hdl = 0;
    if (e_ev) return;
    k = 0;
    while (k < N) begin
      if (slot_vld[k] && (slot_flt[k] || slot_trp[k] || (tb_en && slot_brt[k]))) break;
      k++;
    end
    for (int j = 0; j < N; j++)
      if (slot_vld[j] && (j < k || (j == k && !slot_flt[k]))) p_commit[j] = 1;
    if (k == N) return;
    p_ev = 1;
    if (slot_flt[k]) begin
      p_cause = slot_fcause[k*CW +: CW];
      p_ip = grp_ip + k * STRIDE;
      p_fw = FWM[p_cause];
    end else begin
      p_trap = 1;
      p_cause = slot_trp[k] ? slot_tcause[k*CW +: CW] : CW'(TBC);
      p_ip = slot_brt[k] ? slot_btgt[k*AW +: AW] : grp_ip + (k + 1) * STRIDE;
    end
    p_hdl = p_fw ? FWE : vt_base + (p_trap * 16 + p_cause) * EB;
  endtask

  task automatic cmp(string f, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, f, act, exp);
    end
  endtask

  task automatic check();
    vectors++;
    cmp("commit", 64'(commit), 64'(e_commit));
    cmp("ev_valid", 64'(ev_valid), 64'(e_ev));
    cmp("ev_trap", 64'(ev_trap), 64'(e_trap));
    cmp("ev_cause", 64'(ev_cause), 64'(e_cause));
    cmp("ev_ip", 64'(ev_ip), 64'(e_ip));
    cmp("ev_fw", 64'(ev_fw), 64'(e_fw));
    cmp("ev_handler", 64'(ev_handler), 64'(e_hdl));
  endtask

  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    e_commit = p_commit; e_ev = p_ev; e_trap = p_trap; e_fw = p_fw;
    e_cause = p_cause; e_ip = p_ip; e_hdl = p_hdl;
    check();
  endtask

  task automatic clr();
    slot_vld = 0; slot_flt = 0; slot_trp = 0; slot_brt = 0;
    slot_fcause = 0; slot_tcause = 0; slot_btgt = 0; tb_en = 0;
  endtask

  task automatic idle2();
    clr(); tag = "R9"; step(); step();
  endtask

  initial begin
    grp_ip = 32'h0001_0000; vt_base = 32'h0040_0000;
    slot_vld = '1; slot_flt = 3'b010;
    repeat (3) @(negedge clk);
    tag = "R11"; check();
    rst_n = 1;
    clr();
    // R9 empty group, then a full quiet group
    tag = "R9"; step();
    slot_vld = 3'b111; step();
    slot_vld = 3'b101; step();
    // R1 R2 R4: fault in slot 1 beats trap in slot 2
    idle2(); tag = "R2/R4";
    slot_vld = '1; slot_flt = 3'b010; slot_fcause = 12'h030; slot_trp = 3'b100; step();
    // R3 R5: trap in slot 0
    idle2(); tag = "R3/R5";
    slot_vld = '1; slot_trp = 3'b001; slot_tcause = 12'h002; step();
    // R7: fault and trap and taken branch in one slot
    idle2(); tag = "R7";
    slot_vld = '1; tb_en = 1; slot_flt = 3'b010; slot_trp = 3'b010; slot_brt = 3'b010;
    slot_fcause = 12'h050; slot_tcause = 12'h070; slot_btgt = {32'h0, 32'h0002_2000, 32'h0}; step();
    // R6 R5: taken-branch trap in slot 2 reports the target
    idle2(); tag = "R6";
    slot_vld = '1; tb_en = 1; slot_brt = 3'b100; slot_btgt = {32'h0003_0040, 64'h0}; step();
    // R6: enable low, taken branch is no event
    idle2(); tag = "R6";
    slot_vld = '1; slot_brt = 3'b001; slot_btgt = 96'h1234; step();
    // R8: firmware-handled fault cause 15
    idle2(); tag = "R8";
    slot_vld = '1; slot_flt = 3'b001; slot_fcause = 12'h00F; step();
    // R1: invalid slot 0 with fault flag is ignored, slot 1 trap wins
    idle2(); tag = "R1";
    slot_vld = 3'b110; slot_flt = 3'b001; slot_trp = 3'b010; slot_tcause = 12'h040; step();
    // R10: group right after an event is flushed
    idle2(); tag = "R10";
    slot_vld = '1; slot_trp = 3'b010; step();
    clr(); slot_vld = '1; slot_flt = 3'b001; step();
    step();
    // R5: trap on last slot reports grp_ip + 3*STRIDE
    idle2(); tag = "R5";
    slot_vld = '1; slot_trp = 3'b100; slot_tcause = 12'h300; step();
    idle2();
    // random mix
    tag = "R1-mix";
    for (int n = 0; n < 4000; n++) begin
      grp_ip = $urandom & 32'hFFFF_FFF0;
      vt_base = $urandom & 32'hFFFF_0000;
      tb_en = $urandom;
      slot_vld = $urandom;
      slot_fcause = $urandom; slot_tcause = $urandom;
      slot_btgt = {$urandom, $urandom, $urandom};
      for (int s = 0; s < N; s++) begin
        slot_flt[s] = ($urandom % 7) == 0;
        slot_trp[s] = ($urandom % 6) == 0;
        slot_brt[s] = ($urandom % 5) == 0;
      end
      step();
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end
endmodule